// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

The block multiplies two square N×N matrices of W-bit signed integers on an N×N grid of identical multiply-accumulate cells. Each cell keeps its own running sum. Operands from matrix B enter along the top edge and move down one row per clock. Operands from matrix A enter along the left edge and move right one column per clock. The caller applies the skew: left lane i and top lane j are each delayed by their own index, so that A[i][k] and B[k][j] meet in cell (i,j). All cells step together on one clock, with no handshake between neighbours.

A single-cycle `start` clears every accumulator and opens an accumulation window of 3N−2 cycles. During this window a lane whose valid flag is low feeds a zero into the array, and those zeros serve as the padding that flushes the grid. When the window closes, the finished results are not read from every cell at once. Each cell hands its accumulator to the cell below it, one row per clock, so the product matrix leaves through the bottom edge. The bottom row leaves first, and `done` marks the last row.

Top module: `mesh_matmul`

## Requirements
- R1: While reset is held and right after it, `res_vld` and `done` are low.
- R2: Each emitted row equals the exact signed product row sum over k of A[i][k]·B[k][j]. Column j is carried on `res_data[j*AW +: AW]`, where AW = 2W + log2(N).
- R3: Take the edge that samples `start` as edge 0. Left lane i (`left_data[i*W +: W]`) must carry A[i][k], and top lane j (`top_data[j*W +: W]`) must carry B[k][j], at edge 1+k+i and edge 1+k+j respectively.
- R4: During the accumulation window, a lane whose valid bit is low contributes zero, whatever its data bus carries.
- R5: `res_vld` stays low until the cycle after edge 3N−2. It then stays high for N consecutive cycles, with `res_row` counting down from N−1 to 0 and naming the result row on `res_data`.
- R6: `done` is high only in the cycle that carries row 0. In the following cycle `res_vld` is low.
- R7: A `start` pulse that arrives while a multiplication or its drain is in progress has no effect on timing or results.
- R8: Each accepted `start` clears all accumulators. Operand lanes, even when marked valid, are ignored outside the accumulation window.
- R9: With every operand at the most negative value −2^(W−1), each result equals N·2^(2W−2) exactly, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears accumulators and begins a multiplication when idle |
| top_data | input | N*W | Skewed B operands, one signed lane per column |
| top_vld | input | N | Valid flag per top lane |
| left_data | input | N*W | Skewed A operands, one signed lane per row |
| left_vld | input | N | Valid flag per left lane |
| res_data | output | N*AW | One result row, one signed lane per column |
| res_vld | output | 1 | A result row is present |
| res_row | output | max(1,log2 N) | Index of the row on res_data |
| done | output | 1 | Last result row is present |

## Verification
After the edge that accepts `start`, products accumulate on edges 1 through 3N−2. The first result row is present in the following cycle, and one further row follows on each cycle after that, for N cycles in all. The bench drives each lane on the falling edge before the rising edge that consumes it. It samples outputs on the falling edge after each rising edge. It confirms that `res_vld` is low on every sample inside the window, and it compares the row at drain step r against expected row N−1−r. Expected products are computed in the bench from the same operands, with masked entries taken as zero.

// File: rtl/mm_pkg.sv
package mm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MAC   = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;
endpackage

// File: rtl/mm_pe.sv
module mm_pe #(
    parameter int W  = 8,
    parameter int AW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 mac_en,
    input  logic                 shift_en,
    input  logic signed [W-1:0]  v_in,
    input  logic signed [W-1:0]  h_in,
    input  logic signed [AW-1:0] acc_in,
    output logic signed [W-1:0]  v_out,
    output logic signed [W-1:0]  h_out,
    output logic signed [AW-1:0] acc_out
);
    typedef struct packed {
        logic signed [W-1:0]  v;
        logic signed [W-1:0]  h;
        logic signed [AW-1:0] acc;
    } pe_state_t;

    pe_state_t st_d, st_q;
    logic signed [2*W-1:0] prod;

    always_comb begin
        prod = v_in * h_in;
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (mac_en) begin
            st_d.v   = v_in;
            st_d.h   = h_in;
            st_d.acc = st_q.acc + AW'(prod);
        end else if (shift_en) begin
            st_d.v   = '0;
            st_d.h   = '0;
            st_d.acc = acc_in;
        end else begin
            st_d.v = '0;
            st_d.h = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_out   = st_q.v;
    assign h_out   = st_q.h;
    assign acc_out = st_q.acc;
endmodule

// File: rtl/mm_grid.sv
module mm_grid #(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int AW = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            mac_en,
    input  logic            shift_en,
    input  logic [N*W-1:0]  top_v,
    input  logic [N*W-1:0]  left_h,
    output logic [N*AW-1:0] bot_acc
);
    logic signed [W-1:0]  v_w [N][N];
    logic signed [W-1:0]  h_w [N][N];
    logic signed [AW-1:0] a_w [N][N];

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic signed [W-1:0]  vi;
            logic signed [W-1:0]  hi;
            logic signed [AW-1:0] ai;
            if (r == 0) begin : g_edge_top
                assign vi = $signed(top_v[c*W +: W]);
                assign ai = '0;
            end else begin : g_link_top
                assign vi = v_w[r-1][c];
                assign ai = a_w[r-1][c];
            end
            if (c == 0) begin : g_edge_left
                assign hi = $signed(left_h[r*W +: W]);
            end else begin : g_link_left
                assign hi = h_w[r][c-1];
            end
            mm_pe #(.W(W), .AW(AW)) u_pe (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr),
                .mac_en  (mac_en),
                .shift_en(shift_en),
                .v_in    (vi),
                .h_in    (hi),
                .acc_in  (ai),
                .v_out   (v_w[r][c]),
                .h_out   (h_w[r][c]),
                .acc_out (a_w[r][c])
            );
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_bottom
        assign bot_acc[c*AW +: AW] = a_w[N-1][c];
    end

    logic unused_far_edges;
    always_comb begin
        unused_far_edges = 1'b0;
        for (int k = 0; k < N; k++) begin
            unused_far_edges = unused_far_edges ^ (^v_w[N-1][k]) ^ (^h_w[k][N-1]);
        end
    end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
    parameter int N = 4,
    localparam int MAC_CYC = 3*N - 2,
    localparam int CW = $clog2(MAC_CYC + 1) + 1,
    localparam int RW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          clr,
    output logic          mac_en,
    output logic          shift_en,
    output logic          res_vld,
    output logic [RW-1:0] res_row,
    output logic          done
);
    import mm_pkg::*;

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        clr  = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    clr       = 1'b1;
                    st_d.ph   = PH_MAC;
                    st_d.cnt  = '0;
                end
            end
            PH_MAC: begin
                if (st_q.cnt == CW'(MAC_CYC - 1)) begin
                    st_d.ph  = PH_DRAIN;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_DRAIN: begin
                if (st_q.cnt == CW'(N - 1)) begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mac_en   = (st_q.ph == PH_MAC);
    assign shift_en = (st_q.ph == PH_DRAIN);
    assign res_vld  = (st_q.ph == PH_DRAIN);
    assign res_row  = RW'(N - 1) - st_q.cnt[RW-1:0];
    assign done     = (st_q.ph == PH_DRAIN) && (st_q.cnt == CW'(N - 1));
endmodule

// File: rtl/mesh_matmul.sv
module mesh_matmul #(
    parameter int N = 4,
    parameter int W = 8,
    localparam int AW = 2*W + $clog2(N),
    localparam int RW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N*W-1:0]  top_data,
    input  logic [N-1:0]    top_vld,
    input  logic [N*W-1:0]  left_data,
    input  logic [N-1:0]    left_vld,
    output logic [N*AW-1:0] res_data,
    output logic            res_vld,
    output logic [RW-1:0]   res_row,
    output logic            done
);
    logic clr, mac_en, shift_en;
    logic [N*W-1:0] top_g, left_g;

    mm_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .clr     (clr),
        .mac_en  (mac_en),
        .shift_en(shift_en),
        .res_vld (res_vld),
        .res_row (res_row),
        .done    (done)
    );

    always_comb begin
        for (int j = 0; j < N; j++) begin
            top_g[j*W +: W]  = (mac_en && top_vld[j])  ? top_data[j*W +: W]  : '0;
            left_g[j*W +: W] = (mac_en && left_vld[j]) ? left_data[j*W +: W] : '0;
        end
    end

    mm_grid #(.N(N), .W(W), .AW(AW)) u_grid (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .mac_en  (mac_en),
        .shift_en(shift_en),
        .top_v   (top_g),
        .left_h  (left_g),
        .bot_acc (res_data)
    );
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
    parameter int N = 4,
    localparam int RW = (N > 1) ? $clog2(N) : 1,
    localparam int LAT = 3*N - 1,
    localparam int CNTW = $clog2(LAT + 1) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          res_vld,
    input logic [RW-1:0] res_row,
    input logic          done
);
    logic            chk_busy;
    logic [CNTW-1:0] chk_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_busy <= 1'b0;
            chk_cnt  <= '0;
        end else if (!chk_busy && start) begin
            chk_busy <= 1'b1;
            chk_cnt  <= CNTW'(1);
        end else if (chk_busy) begin
            if (done) chk_busy <= 1'b0;
            if (chk_cnt != '1) chk_cnt <= chk_cnt + CNTW'(1);
        end
    end

    assert_first_row_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_vld) |-> (chk_busy && chk_cnt == CNTW'(LAT)));

    assert_quiet_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_busy && chk_cnt < CNTW'(LAT)) |-> !res_vld);

    assert_first_row_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_vld) |-> (res_row == RW'(N - 1)));

    assert_row_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !done) |=> (res_vld && res_row == $past(res_row) - RW'(1)));

    assert_done_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_vld && res_row == '0));

    assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!res_vld && !done));
endmodule

bind mesh_matmul mm_checker #(.N(N)) u_mm_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .res_vld(res_vld),
    .res_row(res_row),
    .done   (done)
);

// File: tb/test_mesh_matmul.sv
module test_mesh_matmul;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int W  = 8;
    localparam int AW = 2*W + $clog2(N);
    localparam int RW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N*W-1:0]  top_data = '0;
    logic [N-1:0]    top_vld = '0;
    logic [N*W-1:0]  left_data = '0;
    logic [N-1:0]    left_vld = '0;
    logic [N*AW-1:0] res_data;
    logic            res_vld;
    logic [RW-1:0]   res_row;
    logic            done;

    int checks = 0;
    int failures = 0;

    int ma [N][N];
    int mb [N][N];
    bit am [N][N];
    bit bm [N][N];
    int ec [N][N];

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_matmul #(.N(N), .W(W)) i_mesh_matmul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .top_data(top_data), .top_vld(top_vld),
        .left_data(left_data), .left_vld(left_vld),
        .res_data(res_data), .res_vld(res_vld), .res_row(res_row), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd_op();
        return int'($urandom_range(0, (1 << W) - 1)) - (1 << (W - 1));
    endfunction

    task automatic fill_random(input bit with_masks);
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < N; k++) begin
                ma[i][k] = rnd_op();
                mb[i][k] = rnd_op();
                am[i][k] = with_masks ? bit'($urandom_range(0, 3) != 0) : 1'b1;
                bm[i][k] = with_masks ? bit'($urandom_range(0, 3) != 0) : 1'b1;
            end
        end
    endtask

    task automatic calc_expected();
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                ec[i][j] = 0;
                for (int k = 0; k < N; k++) begin
                    ec[i][j] += (am[i][k] ? ma[i][k] : 0) * (bm[k][j] ? mb[k][j] : 0);
                end
            end
        end
    endtask

    task automatic idle_junk(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            top_vld  = '1;
            left_vld = '1;
            for (int j = 0; j < N; j++) begin
                top_data[j*W +: W]  = W'(rnd_op());
                left_data[j*W +: W] = W'(rnd_op());
            end
        end
    endtask

    task automatic run_mm(input string req, input bit poke);
        bit early;
        calc_expected();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early = 1'b0;
        for (int t = 1; t <= 3*N - 2; t++) begin
            if (res_vld || done) early = 1'b1;
            for (int i = 0; i < N; i++) begin
                int k;
                k = t - 1 - i;
                if (k >= 0 && k < N) begin
                    left_vld[i] = am[i][k];
                    left_data[i*W +: W] = am[i][k] ? W'(ma[i][k]) : W'(rnd_op());
                    top_vld[i] = bm[k][i];
                    top_data[i*W +: W] = bm[k][i] ? W'(mb[k][i]) : W'(rnd_op());
                end else begin
                    left_vld[i] = 1'b0;
                    top_vld[i]  = 1'b0;
                    left_data[i*W +: W] = W'(rnd_op());
                    top_data[i*W +: W]  = W'(rnd_op());
                end
            end
            start = poke && (t == 3);
            @(negedge clk);
        end
        start = 1'b0;
        check(!early, "R3 no result inside window", int'(early), 0);
        top_vld  = '0;
        left_vld = '0;
        for (int r = 0; r < N; r++) begin
            bit ok;
            int bad_act, bad_exp;
            start = poke && (r == 0);
            check(res_vld == 1'b1, "R5 res_vld during drain", int'(res_vld), 1);
            check(int'(res_row) == N - 1 - r, "R5 row order", int'(res_row), N - 1 - r);
            check(done == (r == N - 1), "R6 done only on last row", int'(done), int'(r == N - 1));
            ok = 1'b1;
            bad_act = 0;
            bad_exp = 0;
            for (int j = 0; j < N; j++) begin
                int act;
                act = int'($signed(res_data[j*AW +: AW]));
                if (ok && act != ec[N-1-r][j]) begin
                    ok = 1'b0;
                    bad_act = act;
                    bad_exp = ec[N-1-r][j];
                end
            end
            check(ok, req, bad_act, bad_exp);
            @(negedge clk);
        end
        start = 1'b0;
        check(!res_vld && !done, "R6 idle after last row", int'(res_vld), 0);
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        check(res_vld == 1'b0, "R1 res_vld in reset", int'(res_vld), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_vld == 1'b0 && done == 1'b0, "R1 idle after reset", int'(res_vld), 0);

        // R2 directed: identity times random
        fill_random(1'b0);
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) ma[i][k] = (i == k) ? 1 : 0;
        run_mm("R2 identity product", 1'b0);

        // R9 extreme negatives
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = -(1 << (W - 1));
                mb[i][k] = -(1 << (W - 1));
                am[i][k] = 1'b1;
                bm[i][k] = 1'b1;
            end
        run_mm("R9 most negative operands", 1'b0);

        // R8 junk while idle, then accumulators must restart from zero
        idle_junk(6);
        fill_random(1'b0);
        run_mm("R8 junk while idle ignored", 1'b0);
        fill_random(1'b0);
        run_mm("R8 back-to-back clear", 1'b0);

        // R4 masked lanes contribute zero
        for (int n = 0; n < 3; n++) begin
            fill_random(1'b1);
            run_mm("R4 masked lanes", 1'b0);
        end

        // R7 start pulses mid-window and mid-drain
        fill_random(1'b0);
        run_mm("R7 start while busy", 1'b0);
        fill_random(1'b0);
        run_mm("R7 start while busy", 1'b1);

        // R2 random
        for (int n = 0; n < 5; n++) begin
            fill_random(1'b0);
            run_mm("R2 random product", 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule